// File: doc/BRIEF.md
# Per-Thread Squash Request Arbiter

This block lives in the execute/writeback stage of an out-of-order core. During each arbitration window it gathers squash requests for every hardware thread and keeps, per thread, one squash record that is handed on toward commit. A record holds a valid flag, the squashed sequence number, the redirect PC, a branch-mispredict flag and an include-squashing-instruction flag.

Requests arrive one per clock on a single request bus. There are three kinds: resolved branch mispredictions, memory-ordering violations reported by the load/store queue, and blocked memory accesses. A window opens with `win_start`, which wipes every thread's record. Each later request is judged against the record built so far in that window. The oldest acceptable request (lowest sequence number) wins. For an ordering violation, the age that counts is the violating instruction's, not the detecting one's. Sequence numbers are unsigned and do not wrap.

Top module: `squash_arbiter`

## Requirements
- R1: After synchronous reset, every thread's record shows valid 0, sequence 0, redirect PC 0, and both flags 0.
- R2: A cycle with `win_start` high clears every thread's record. A request in that same cycle is judged against the cleared record, so it is accepted.
- R3: A branch request (kind 2'b00) accepted into an empty record stores the request's sequence number and its next PC as the redirect. It sets mispredict to 1 and include to 0.
- R4: A branch request replaces a valid record only when its sequence number is strictly smaller than the recorded one. An equal or larger number leaves the record unchanged.
- R5: An accepted ordering-violation request (kind 2'b01) stores the violator's sequence number and the violator's next PC. It clears both mispredict and include.
- R6: An ordering-violation request is ignored when the record is valid and the violator's sequence number is greater than or equal to the recorded one. This holds even when the detecting instruction is older than the recorded one.
- R7: An accepted blocked-memory request (kind 2'b10) stores the request's sequence number and the request's own PC. It sets include to 1 and mispredict to 0.
- R8: A blocked-memory request replaces a valid record only when its sequence number is strictly smaller than the recorded one.
- R9: A request updates only the record of the thread named by `req_tid`. Every other thread's record is unchanged.
- R10: A request with kind 2'b11, or any cycle with `req_valid` low, changes no record.
- R11: Records are registered. A request sampled at a clock edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Opens a new arbitration window and clears all records |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 branch, 01 ordering violation, 10 blocked memory, 11 reserved |
| req_tid | input | TID_W | Target thread |
| req_seq | input | SEQ_W | Sequence number of the requesting or detecting instruction |
| req_pc | input | PC_W | PC of the requesting instruction |
| req_npc | input | PC_W | Next PC of the requesting instruction |
| req_vseq | input | SEQ_W | Violator sequence number (ordering violation only) |
| req_vnpc | input | PC_W | Violator next PC (ordering violation only) |
| out_valid | output | THREADS | Per-thread squash valid |
| out_seq | output | THREADS*SEQ_W | Per-thread squashed sequence number |
| out_pc | output | THREADS*PC_W | Per-thread redirect PC |
| out_mispred | output | THREADS | Per-thread branch-mispredict flag |
| out_incl | output | THREADS | Per-thread include-squashing-instruction flag |

## Verification
The bench targets equal sequence numbers. A design that used a non-strict comparison would let a younger-or-equal request overwrite the record. It also sends ordering violations whose detector is older than the record but whose violator is not. A design that compared the detecting instruction's age would accept these wrongly. The bench checks that a request arriving together with `win_start` is judged against an empty record, not against the previous window's record. It also checks that the redirect PC and flags follow each request kind: a swapped PC or include flag shows up at once in the record. Random request mixes across both threads are compared against an oldest-wins model, which catches leakage between threads.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;
  typedef enum logic [1:0] {
    K_BRANCH  = 2'b00,
    K_ORDER   = 2'b01,
    K_BLOCKED = 2'b10,
    K_RSVD    = 2'b11
  } sq_kind_e;
endpackage

// File: rtl/sqarb_decode.sv
module sqarb_decode
  import sqarb_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [SEQ_W-1:0]   req_seq,
  input  logic [PC_W-1:0]    req_pc,
  input  logic [PC_W-1:0]    req_npc,
  input  logic [SEQ_W-1:0]   req_vseq,
  input  logic [PC_W-1:0]    req_vnpc,
  output logic               cand_ok,
  output logic [SEQ_W-1:0]   cand_seq,
  output logic [PC_W-1:0]    cand_pc,
  output logic               cand_mis,
  output logic               cand_inc,
  output logic [THREADS-1:0] hit_vec
);
  sq_kind_e kind;
  assign kind = sq_kind_e'(req_kind);

  // Shape a candidate record from the request according to its kind.
  always_comb begin
    cand_ok  = 1'b0;
    cand_seq = req_seq;
    cand_pc  = req_npc;
    cand_mis = 1'b0;
    cand_inc = 1'b0;
    if (req_valid) begin
      unique case (kind)
        K_BRANCH: begin
          cand_ok  = 1'b1;
          cand_mis = 1'b1;
        end
        K_ORDER: begin
          cand_ok  = 1'b1;
          cand_seq = req_vseq;
          cand_pc  = req_vnpc;
        end
        K_BLOCKED: begin
          cand_ok  = 1'b1;
          cand_pc  = req_pc;
          cand_inc = 1'b1;
        end
        default: cand_ok = 1'b0;
      endcase
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_hit
    assign hit_vec[t] = cand_ok && (req_tid == TID_W'(t));
  end

  AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (rst) (req_kind == 2'b11 || !req_valid) |-> (hit_vec == '0)) else $error("reserved kind reached a slot"); // R10
  AST_ONE_THREAD: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec)) else $error("request hit more than one thread"); // R9
endmodule

// File: rtl/sqarb_slot.sv
module sqarb_slot #(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_start,
  input  logic             hit,
  input  logic [SEQ_W-1:0] cand_seq,
  input  logic [PC_W-1:0]  cand_pc,
  input  logic             cand_mis,
  input  logic             cand_inc,
  output logic             rec_valid,
  output logic [SEQ_W-1:0] rec_seq,
  output logic [PC_W-1:0]  rec_pc,
  output logic             rec_mis,
  output logic             rec_inc
);
  logic pending;
  logic older;
  logic take;

  // The window opening wipes the record before this cycle's request is judged.
  assign pending = rec_valid && !win_start;
  assign older   = cand_seq < rec_seq;
  assign take    = hit && (!pending || older);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_seq   <= '0;
      rec_pc    <= '0;
      rec_mis   <= 1'b0;
      rec_inc   <= 1'b0;
    end else if (take) begin
      rec_valid <= 1'b1;
      rec_seq   <= cand_seq;
      rec_pc    <= cand_pc;
      rec_mis   <= cand_mis;
      rec_inc   <= cand_inc;
    end else if (win_start) begin
      rec_valid <= 1'b0;
      rec_seq   <= '0;
      rec_pc    <= '0;
      rec_mis   <= 1'b0;
      rec_inc   <= 1'b0;
    end
  end

  AST_YOUNGER_KEEPS: assert property (@(posedge clk) disable iff (rst) (hit && !win_start && rec_valid && cand_seq >= rec_seq) |=> ($stable(rec_seq) && $stable(rec_pc) && $stable(rec_mis) && $stable(rec_inc))) else $error("younger request replaced record"); // R4
  AST_FIRST_TAKEN: assert property (@(posedge clk) disable iff (rst) (hit && (win_start || !rec_valid)) |=> (rec_valid && rec_seq == $past(cand_seq))) else $error("first request not taken"); // R2
  AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (rst) (win_start && !hit) |=> !rec_valid) else $error("window start left record valid"); // R2
  AST_AGE_NONINC: assert property (@(posedge clk) disable iff (rst) (rec_valid && !win_start) |=> (rec_valid && rec_seq <= $past(rec_seq))) else $error("record got younger within window"); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) rec_valid |-> !(rec_mis && rec_inc)) else $error("both flags set"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!hit && !win_start) |=> ($stable(rec_valid) && $stable(rec_seq) && $stable(rec_pc))) else $error("record moved without a request"); // R10
endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter #(
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     win_start,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [TID_W-1:0]         req_tid,
  input  logic [SEQ_W-1:0]         req_seq,
  input  logic [PC_W-1:0]          req_pc,
  input  logic [PC_W-1:0]          req_npc,
  input  logic [SEQ_W-1:0]         req_vseq,
  input  logic [PC_W-1:0]          req_vnpc,
  output logic [THREADS-1:0]       out_valid,
  output logic [THREADS*SEQ_W-1:0] out_seq,
  output logic [THREADS*PC_W-1:0]  out_pc,
  output logic [THREADS-1:0]       out_mispred,
  output logic [THREADS-1:0]       out_incl
);
  logic               cand_ok;
  logic [SEQ_W-1:0]   cand_seq;
  logic [PC_W-1:0]    cand_pc;
  logic               cand_mis;
  logic               cand_inc;
  logic [THREADS-1:0] hit_vec;

  sqarb_decode #(
    .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W)
  ) u_dec (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_tid(req_tid),
    .req_seq(req_seq), .req_pc(req_pc), .req_npc(req_npc),
    .req_vseq(req_vseq), .req_vnpc(req_vnpc),
    .cand_ok(cand_ok), .cand_seq(cand_seq), .cand_pc(cand_pc),
    .cand_mis(cand_mis), .cand_inc(cand_inc), .hit_vec(hit_vec)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_slot
    sqarb_slot #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_slot (
      .clk(clk), .rst(rst), .win_start(win_start), .hit(hit_vec[t]),
      .cand_seq(cand_seq), .cand_pc(cand_pc),
      .cand_mis(cand_mis), .cand_inc(cand_inc),
      .rec_valid(out_valid[t]),
      .rec_seq(out_seq[t*SEQ_W +: SEQ_W]),
      .rec_pc(out_pc[t*PC_W +: PC_W]),
      .rec_mis(out_mispred[t]),
      .rec_inc(out_incl[t])
    );
  end

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst) (!win_start && req_valid && req_tid == '0) |=> $stable(out_valid[THREADS-1:1]) || (THREADS == 1)) else $error("other thread changed"); // R9
endmodule

// File: tb/tb_squash_arbiter.sv
`timescale 1ns/1ps
module tb_squash_arbiter;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst;
  logic win_start, req_valid;
  logic [1:0] req_kind;
  logic [0:0] req_tid;
  logic [SW-1:0] req_seq, req_vseq;
  logic [PW-1:0] req_pc, req_npc, req_vnpc;
  logic [NT-1:0] out_valid, out_mispred, out_incl;
  logic [NT*SW-1:0] out_seq;
  logic [NT*PW-1:0] out_pc;

  always #2 clk = ~clk;

  squash_arbiter #(.THREADS(NT), .SEQ_W(SW), .PC_W(PW)) dut (
    .clk(clk), .rst(rst), .win_start(win_start), .req_valid(req_valid),
    .req_kind(req_kind), .req_tid(req_tid), .req_seq(req_seq), .req_pc(req_pc),
    .req_npc(req_npc), .req_vseq(req_vseq), .req_vnpc(req_vnpc),
    .out_valid(out_valid), .out_seq(out_seq), .out_pc(out_pc),
    .out_mispred(out_mispred), .out_incl(out_incl)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          m_valid [NT];
  logic [SW-1:0] m_seq [NT];
  logic [PW-1:0] m_pc [NT];
  logic          m_mis [NT];
  logic          m_inc [NT];

  task automatic m_clear();
    for (int t = 0; t < NT; t++) begin
      m_valid[t] = 0; m_seq[t] = '0; m_pc[t] = '0; m_mis[t] = 0; m_inc[t] = 0;
    end
  endtask

  // Model the acceptance rules straight from the requirements.
  task automatic m_apply(input logic [1:0] k, input int t, input logic [SW-1:0] s,
                         input logic [PW-1:0] pc, input logic [PW-1:0] npc,
                         input logic [SW-1:0] vs, input logic [PW-1:0] vnpc);
    logic [SW-1:0] es;
    if (k == 2'b11) return;
    es = (k == 2'b01) ? vs : s;
    if (m_valid[t] && es >= m_seq[t]) return;
    m_valid[t] = 1; m_seq[t] = es;
    m_pc[t]  = (k == 2'b00) ? npc : (k == 2'b01) ? vnpc : pc;
    m_mis[t] = (k == 2'b00);
    m_inc[t] = (k == 2'b10);
  endtask

  task automatic send(input bit st, input bit v, input logic [1:0] k, input int t,
                      input logic [SW-1:0] s, input logic [PW-1:0] pc, input logic [PW-1:0] npc,
                      input logic [SW-1:0] vs, input logic [PW-1:0] vnpc);
    win_start = st; req_valid = v; req_kind = k; req_tid = t[0:0];
    req_seq = s; req_pc = pc; req_npc = npc; req_vseq = vs; req_vnpc = vnpc;
    if (st) m_clear();
    if (v) m_apply(k, t, s, pc, npc, vs, vnpc);
    @(negedge clk);
    win_start = 0; req_valid = 0;
  endtask

  task automatic check_thread(input int t, input string rq);
    logic [SW-1:0] as_;
    logic [PW-1:0] ap;
    as_ = out_seq[t*SW +: SW];
    ap  = out_pc[t*PW +: PW];
    checks++;
    if (out_valid[t] !== m_valid[t] || as_ !== m_seq[t] || ap !== m_pc[t] ||
        out_mispred[t] !== m_mis[t] || out_incl[t] !== m_inc[t]) begin
      errors++;
      $display("FAIL %s thread %0d: got v=%0b seq=%0d pc=%h mis=%0b inc=%0b exp v=%0b seq=%0d pc=%h mis=%0b inc=%0b",
               rq, t, out_valid[t], as_, ap, out_mispred[t], out_incl[t],
               m_valid[t], m_seq[t], m_pc[t], m_mis[t], m_inc[t]);
    end
  endtask

  task automatic check_lit(input int t, input string rq, input logic [SW-1:0] es,
                           input logic [PW-1:0] ep, input bit em, input bit ei);
    checks++;
    if (out_valid[t] !== 1'b1 || out_seq[t*SW +: SW] !== es || out_pc[t*PW +: PW] !== ep ||
        out_mispred[t] !== em || out_incl[t] !== ei) begin
      errors++;
      $display("FAIL %s thread %0d: got v=%0b seq=%0d pc=%h mis=%0b inc=%0b exp v=1 seq=%0d pc=%h mis=%0b inc=%0b",
               rq, t, out_valid[t], out_seq[t*SW +: SW], out_pc[t*PW +: PW],
               out_mispred[t], out_incl[t], es, ep, em, ei);
    end
  endtask

  task automatic t_reset();
    m_clear();
    check_thread(0, "R1"); check_thread(1, "R1");
  endtask

  task automatic t_branch();
    send(1, 1, 2'b00, 0, 16'd100, 32'h1000, 32'h2000, 0, 0);
    check_lit(0, "R3 R11", 16'd100, 32'h2000, 1, 0);
    send(0, 1, 2'b00, 0, 16'd120, 32'h1100, 32'h2100, 0, 0);
    check_lit(0, "R4 younger", 16'd100, 32'h2000, 1, 0);
    send(0, 1, 2'b00, 0, 16'd100, 32'h1200, 32'h2200, 0, 0);
    check_lit(0, "R4 equal", 16'd100, 32'h2000, 1, 0);
    send(0, 1, 2'b00, 0, 16'd90, 32'h1300, 32'h2300, 0, 0);
    check_lit(0, "R4 older", 16'd90, 32'h2300, 1, 0);
  endtask

  task automatic t_order();
    send(1, 1, 2'b01, 0, 16'd50, 32'hA0, 32'hA4, 16'd40, 32'hB4);
    check_lit(0, "R5", 16'd40, 32'hB4, 0, 0);
    send(0, 1, 2'b01, 0, 16'd10, 32'hC0, 32'hC4, 16'd45, 32'hD4);
    check_lit(0, "R6 old detector", 16'd40, 32'hB4, 0, 0);
    send(0, 1, 2'b01, 0, 16'd60, 32'hC0, 32'hC4, 16'd40, 32'hE4);
    check_lit(0, "R6 equal violator", 16'd40, 32'hB4, 0, 0);
    send(0, 1, 2'b01, 0, 16'd60, 32'hC0, 32'hC4, 16'd30, 32'hF4);
    check_lit(0, "R6 older violator", 16'd30, 32'hF4, 0, 0);
  endtask

  task automatic t_blocked();
    send(1, 1, 2'b10, 1, 16'd200, 32'h300, 32'h304, 0, 0);
    check_lit(1, "R7", 16'd200, 32'h300, 0, 1);
    send(0, 1, 2'b10, 1, 16'd200, 32'h310, 32'h314, 0, 0);
    check_lit(1, "R8 equal", 16'd200, 32'h300, 0, 1);
    send(0, 1, 2'b10, 1, 16'd199, 32'h320, 32'h324, 0, 0);
    check_lit(1, "R8 older", 16'd199, 32'h320, 0, 1);
  endtask

  task automatic t_threads();
    send(1, 1, 2'b00, 0, 16'd500, 32'h40, 32'h44, 0, 0);
    send(0, 1, 2'b10, 1, 16'd5, 32'h50, 32'h54, 0, 0);
    check_thread(0, "R9"); check_thread(1, "R9");
  endtask

  task automatic t_ignore();
    send(1, 1, 2'b00, 0, 16'd300, 32'h60, 32'h64, 0, 0);
    send(0, 1, 2'b11, 0, 16'd1, 32'h70, 32'h74, 16'd1, 32'h78);
    check_lit(0, "R10 reserved", 16'd300, 32'h64, 1, 0);
    send(0, 0, 2'b00, 0, 16'd2, 32'h80, 32'h84, 0, 0);
    check_lit(0, "R10 no valid", 16'd300, 32'h64, 1, 0);
  endtask

  task automatic t_window();
    send(1, 1, 2'b00, 0, 16'd10, 32'h90, 32'h94, 0, 0);
    send(1, 1, 2'b10, 0, 16'd900, 32'h98, 32'h9C, 0, 0);
    check_lit(0, "R2 start plus request", 16'd900, 32'h98, 0, 1);
    send(1, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    check_thread(0, "R2 clear"); check_thread(1, "R2 clear");
  endtask

  task automatic t_random();
    for (int w = 0; w < 40; w++) begin
      for (int i = 0; i < 7; i++) begin
        logic [1:0] k;
        k = 2'($urandom_range(0, 3));
        send(i == 0, 1, k, $urandom_range(0, 1), 16'($urandom_range(0, 31)),
             $urandom, $urandom, 16'($urandom_range(0, 31)), $urandom);
      end
      check_thread(0, "R4 R6 R8 random"); check_thread(1, "R4 R6 R8 random");
    end
  endtask

  initial begin
    rst = 1; win_start = 0; req_valid = 0; req_kind = 0; req_tid = 0;
    req_seq = 0; req_pc = 0; req_npc = 0; req_vseq = 0; req_vnpc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_branch();
    t_order();
    t_blocked();
    t_threads();
    t_ignore();
    t_window();
    t_random();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule